// File: doc/BRIEF.md
# Bus hold acknowledge controller

This block sequences the bus states of a processor bus interface and hands the system bus to an outside master on request. It steps between an idle state, a first bus state, a data-wait state and a granted state. It samples the outside master's request only on the internal phase-1 strobe. When the grant is given it raises the acknowledge and withdraws the enable that drives the address, data and control pins.

A grant is only given at a cycle boundary with the lock input low. That boundary is either the idle state or the end of a data state in which ready was seen low. Locked cycles therefore run back to back while a request waits. When the request is withdrawn, the sequencer goes straight into a new bus cycle if the core has one pending, and otherwise returns to idle.

A rising edge on the non-maskable interrupt input is captured at all times. While the bus is granted it is kept hidden, and it shows up as pending on the first cycle after the grant ends. It stays pending until the core acknowledges it.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the state becomes idle (bus_state 0), hlda 0, pin_oe 1 and nmi_pend 0, and this holds even when the block was in the granted state.
- R2: The state changes only on a clock edge where ph1 is 1; on any edge with ph1 at 0 (and rst_n high), bus_state keeps its value.
- R3: From idle (0) on a ph1 edge: if hold is 1 and lock is 0, go to granted (3); otherwise, if req is 1, go to first state (1); otherwise stay idle.
- R4: The first state (1) always moves to the data state (2) on the next ph1 edge. The data state stays put on ph1 edges while ready_n is 1.
- R5: From the data state (2) on a ph1 edge with ready_n 0 (cycle complete): if hold is 1 and lock is 0, go to granted (3); otherwise go to first state (1) if req is 1, or to idle (0) if not. While lock is 1, a request never leads to a grant.
- R6: From granted (3) on a ph1 edge: if hold is 0, go to first state (1) when req is 1 or to idle (0) when req is 0; while hold stays 1 the block stays granted whatever lock, ready_n and req do.
- R7: hlda is 1 and pin_oe is 0 exactly in the cycles where bus_state is 3; in every other state hlda is 0 and pin_oe is 1.
- R8: A 0-to-1 change of nmi, seen between two consecutive clock edges, is latched. While bus_state is 3, nmi_pend reads 0. An edge latched in the granted state appears on nmi_pend in the first cycle after the state leaves 3.
- R9: nmi_ack high at an edge outside the granted state clears the latch. A new nmi edge at that same edge wins and leaves it set. nmi_ack has no effect while bus_state is 3.
- R10: If hold is 1 when rst_n is released, the first ph1 edge grants the bus (state 3) even when req is 1, so no bus cycle runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph1 | input | 1 | Phase-1 strobe; the state advances only on edges where it is 1 |
| hold | input | 1 | Request for the bus from an outside master |
| lock | input | 1 | Locked sequence in progress; defers any grant |
| req | input | 1 | Core has a bus cycle pending |
| ready_n | input | 1 | Active-low cycle-complete from the addressed device |
| nmi | input | 1 | Edge-triggered non-maskable interrupt |
| nmi_ack | input | 1 | Core accepted the pending interrupt |
| hlda | output | 1 | Bus grant acknowledge |
| pin_oe | output | 1 | Drive enable for address, data and control pins |
| bus_state | output | 2 | 0 idle, 1 first state, 2 data state, 3 granted |
| nmi_pend | output | 1 | Latched interrupt, shown only outside the granted state |

## Verification
Reaching the transitions out of each state under every input mix is hardest. The data and granted states exist only after a specific run of ph1 edges. The bench therefore resets, steers the block into each of the four states, and applies all 32 combinations of ph1, hold, lock, req and ready_n, each in turn. It compares the result with the rule from the requirements. Directed runs add the long locked chain, the reset release with a waiting request, and interrupt edges and acknowledges arriving while the bus is granted.

// File: rtl/hold_pkg.sv
// Shared types for the bus hold controller.
// Assumes a two-bit state code that the pins and the checker both decode.
package hold_pkg;
    localparam int BS_W = 2;

    typedef enum logic [BS_W-1:0] {
        BS_IDLE = 2'd0,
        BS_T1   = 2'd1,
        BS_T2   = 2'd2,
        BS_HOLD = 2'd3
    } bus_st_t;
endpackage

// File: rtl/bus_state_seq.sv
// Bus state sequencer: walks idle, first, data and granted states.
// Assumes ph1 marks the clock edge that starts an internal phase 1; all
// inputs are sampled only there. Grants happen only at cycle boundaries
// (idle or a completed data state) with lock low.
module bus_state_seq
    import hold_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ph1,
    input  logic    hold,
    input  logic    lock,
    input  logic    req,
    input  logic    ready_n,
    output bus_st_t state
);
    bus_st_t nxt;
    logic    grant_ok;
    bus_st_t after_cycle;

    // Grant allowed only when the master asks and no locked run is open.
    assign grant_ok = hold && !lock;

    // State chosen at any boundary that does not grant the bus.
    assign after_cycle = req ? BS_T1 : BS_IDLE;

    // Next-state choice, evaluated only on phase-1 edges.
    always_comb begin
        nxt = state;
        if (ph1) begin
            unique case (state)
                BS_IDLE: nxt = grant_ok ? BS_HOLD : after_cycle;
                BS_T1:   nxt = BS_T2;
                BS_T2: begin
                    if (!ready_n) begin
                        nxt = grant_ok ? BS_HOLD : after_cycle;
                    end
                end
                BS_HOLD: begin
                    if (!hold) begin
                        nxt = after_cycle;
                    end
                end
                default: nxt = BS_IDLE;
            endcase
        end
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BS_IDLE;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/nmi_hold_latch.sv
// Interrupt edge latch: captures rising edges of nmi every clock and
// hides the pending flag while the bus is granted.
// Assumes nmi is already synchronous to clk.
module nmi_hold_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic in_hold,
    input  logic nmi,
    input  logic nmi_ack,
    output logic nmi_pend
);
    logic nmi_q;
    logic pend_r;
    logic rise;

    assign rise = nmi && !nmi_q;

    // Previous sample of nmi for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= nmi;
        end
    end

    // Pending latch: a new edge wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r <= 1'b0;
        end else if (rise) begin
            pend_r <= 1'b1;
        end else if (nmi_ack && !in_hold) begin
            pend_r <= 1'b0;
        end
    end

    // Report only outside the granted state.
    assign nmi_pend = pend_r && !in_hold;
endmodule

// File: rtl/bus_pin_ctl.sv
// Pin control: decodes the state into the grant acknowledge and the
// drive enable for the address, data and control pin groups.
// Assumes the acknowledge pin itself is always driven.
module bus_pin_ctl
    import hold_pkg::*;
(
    input  bus_st_t state,
    output logic    in_hold,
    output logic    hlda,
    output logic    pin_oe
);
    // Grant decode shared by the acknowledge and the drive enable.
    always_comb begin
        in_hold = (state == BS_HOLD);
        hlda    = in_hold;
        pin_oe  = !in_hold;
    end
endmodule

// File: rtl/bus_hold_ctrl.sv
// Top of the bus hold controller. Ties the sequencer, the pin decode and
// the interrupt latch together and exposes the state as a two-bit code.
// Assumes all inputs are synchronous to clk.
module bus_hold_ctrl
    import hold_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ph1,
    input  logic            hold,
    input  logic            lock,
    input  logic            req,
    input  logic            ready_n,
    input  logic            nmi,
    input  logic            nmi_ack,
    output logic            hlda,
    output logic            pin_oe,
    output logic [BS_W-1:0] bus_state,
    output logic            nmi_pend
);
    bus_st_t st;
    logic    in_hold;

    bus_state_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph1     (ph1),
        .hold    (hold),
        .lock    (lock),
        .req     (req),
        .ready_n (ready_n),
        .state   (st)
    );

    bus_pin_ctl u_pins (
        .state   (st),
        .in_hold (in_hold),
        .hlda    (hlda),
        .pin_oe  (pin_oe)
    );

    nmi_hold_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_hold  (in_hold),
        .nmi      (nmi),
        .nmi_ack  (nmi_ack),
        .nmi_pend (nmi_pend)
    );

    assign bus_state = st;
endmodule

// File: rtl/bus_hold_chk.sv
// Checker for the bus hold controller, bound to the top module.
// Observes ports only.
module bus_hold_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ph1,
    input logic       hold,
    input logic       lock,
    input logic       hlda,
    input logic       pin_oe,
    input logic [1:0] bus_state,
    input logic       nmi_pend
);
    p_grant_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda == (bus_state == 2'd3)) && (pin_oe == !hlda));

    p_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ph1 |=> $stable(bus_state));

    p_first_to_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1 && bus_state == 2'd1) |=> bus_state == 2'd2);

    p_lock_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1 && lock && bus_state != 2'd3) |=> bus_state != 2'd3);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1 && bus_state == 2'd3 && !hold) |=> bus_state != 2'd3);

    p_nmi_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !nmi_pend);
endmodule

bind bus_hold_ctrl bus_hold_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph1       (ph1),
    .hold      (hold),
    .lock      (lock),
    .hlda      (hlda),
    .pin_oe    (pin_oe),
    .bus_state (bus_state),
    .nmi_pend  (nmi_pend)
);

// File: tb/tb_bus_hold_ctrl.sv
`timescale 1ns/1ps
module tb_bus_hold_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ph1 = 1'b0, hold = 1'b0, lock = 1'b0, req = 1'b0;
    logic       ready_n = 1'b1, nmi = 1'b0, nmi_ack = 1'b0;
    logic       hlda, pin_oe, nmi_pend;
    logic [1:0] bus_state;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    bus_hold_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ph1(ph1), .hold(hold), .lock(lock),
        .req(req), .ready_n(ready_n), .nmi(nmi), .nmi_ack(nmi_ack),
        .hlda(hlda), .pin_oe(pin_oe), .bus_state(bus_state),
        .nmi_pend(nmi_pend)
    );

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One clock: inputs were set before, outputs sampled at the negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ph1 = 0; hold = 0; lock = 0; req = 0; ready_n = 1; nmi = 0; nmi_ack = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    // Rule from R2..R6 for the state after one edge.
    function automatic int exp_next(int s, bit p, bit h, bit l, bit r, bit rn);
        int bnd;
        bnd = (h && !l) ? 3 : (r ? 1 : 0);
        if (!p) return s;
        case (s)
            0: return bnd;
            1: return 2;
            2: return rn ? 2 : bnd;
            default: return h ? 3 : (r ? 1 : 0);
        endcase
    endfunction

    task automatic go_state(input int s);
        do_reset();
        if (s == 3) begin
            ph1 = 1; hold = 1; step();
        end else if (s >= 1) begin
            ph1 = 1; req = 1; step();
            if (s == 2) begin req = 0; step(); end
        end
        idle_inputs();
        check("R3 setup", bus_state, s);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset values
        check("R1 state", bus_state, 0);
        check("R1 hlda", hlda, 0);
        check("R1 pin_oe", pin_oe, 1);
        check("R1 nmi_pend", nmi_pend, 0);

        // Sweep all states and input mixes (R2 R3 R4 R5 R6 R7)
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 32; v++) begin
                int e;
                go_state(s);
                ph1 = v[4]; hold = v[3]; lock = v[2]; req = v[1]; ready_n = v[0];
                e = exp_next(s, v[4], v[3], v[2], v[1], v[0]);
                step();
                check("R2-6 next state", bus_state, e);
                check("R7 hlda", hlda, (e == 3) ? 1 : 0);
                check("R7 pin_oe", pin_oe, (e == 3) ? 0 : 1);
            end
        end

        // R1: reset from the granted state
        go_state(3);
        hold = 1; rst_n = 0; step(); rst_n = 1;
        check("R1 reset exits grant", bus_state, 0);
        check("R1 hlda after reset", hlda, 0);

        // R10: hold waiting at reset release beats a pending request
        idle_inputs();
        hold = 1; req = 1; rst_n = 0; step(); step(); rst_n = 1;
        step();
        check("R10 no ph1 yet", bus_state, 0);
        ph1 = 1; step();
        check("R10 grant first", bus_state, 3);

        // R5: locked chain keeps running with hold waiting, grant after unlock
        do_reset();
        ph1 = 1; lock = 1; req = 1; hold = 1; ready_n = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            check("R5 locked chain", bus_state, (k % 2 == 0) ? 1 : 2);
        end
        lock = 0; step();
        check("R5 grant after unlock", bus_state, 3);

        // R8: edge during grant hidden, shown after exit
        do_reset();
        ph1 = 1; hold = 1; step();
        nmi = 1; step(); nmi = 0; step();
        check("R8 hidden in grant", nmi_pend, 0);
        hold = 0; step();
        check("R8 state left grant", bus_state, 0);
        check("R8 shown after exit", nmi_pend, 1);

        // R9: acknowledge clears
        nmi_ack = 1; step(); nmi_ack = 0;
        check("R9 ack clears", nmi_pend, 0);
        // R9: edge and ack together leave it set
        nmi = 1; nmi_ack = 1; step(); nmi = 0; nmi_ack = 0;
        check("R9 edge beats ack", nmi_pend, 1);
        // R9: ack while granted is ignored
        hold = 1; step();
        check("R9 hidden in grant", nmi_pend, 0);
        nmi_ack = 1; step(); nmi_ack = 0;
        hold = 0; step();
        check("R9 ack ignored in grant", nmi_pend, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule